// File: doc/BRIEF.md
# Single-Cycle 8-bit Register CPU Core

This block is a small 8-bit processor core that retires exactly one instruction on every rising clock edge. On each clock the program counter addresses a constant program store. The 16-bit word found there is decoded, the operands are read from a bank of four 8-bit registers, the ALU forms the result and the write-back happens. The next program counter, either sequential or a branch target, is also chosen in that same cycle. Nothing is pipelined, so a branch takes effect on the very next instruction, with no delay slot.

The program is given to the core as a constant array parameter at elaboration time. A system that embeds the core selects its firmware by parameter and watches its progress through the program-counter and register debug ports. The arithmetic and logic operations work on a destination register together with either a second register or an 8-bit immediate. Shift, negate and invert act on the destination register alone. Control flow is an unconditional jump and a jump taken when a named register is zero.

Top module: `nano8_core`

## Requirements
- R1: A low level on rst_n clears all four registers and the program counter at once, without waiting for a clock edge. Release is synchronised through two flops, so the instruction at address 0 retires on the third rising edge after rst_n goes high.
- R2: One instruction retires on every rising edge. Every instruction other than a taken branch advances the 8-bit program counter by one, and the count wraps from 255 to 0.
- R3: The word layout is as follows. Bits [15:12] hold the opcode, bit 11 set selects the immediate, bits [10:9] name the destination (or tested) register, and bits [7:0] hold the immediate or jump target, with the source register index in bits [1:0]. The opcode values are: 0 idle, 1 add, 2 subtract, 3 negate, 4 multiply, 5 move, 6 shift left, 7 shift right, 8 and, 9 or, 10 xor, 11 invert, 12 jump-if-zero, 13 jump.
- R4: Add, subtract and multiply write the low 8 bits of dst op src back to the destination, so results wrap modulo 256.
- R5: Move copies the source operand (register or immediate) into the destination.
- R6: And, or and xor write the bitwise combination of the destination and the source operand.
- R7: Negate (two's complement), shift left, shift right (both zero-filled, by one bit) and invert act on the destination alone, ignoring bit 11 and bits [7:0].
- R8: Jump-if-zero loads the program counter with bits [7:0] when the named register equals zero, and otherwise advances it by one.
- R9: Jump loads the program counter with bits [7:0] unconditionally.
- R10: The idle opcode, the two jumps and the unassigned opcodes 14 and 15 write no register, whatever their other fields hold.
- R11: A writing instruction changes only its destination register.
- R12: In register mode, bits [7:2] of the word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| pc_o | output | 8 | Address of the instruction that retires on the next edge |
| regs_o | output | 32 | Register bank, register i in bits [8i+7:8i] |

## Verification
Each instruction becomes visible on the debug ports one clock after it executes, so a wrong decode, operand selection or ALU result shows up as a wrong register value at the very next sample. A wrong next-PC choice shows at pc_o in that same cycle. Later instructions read the corrupted register, so the error also spreads into later values. The program is built so that every register feeds later results, and branch outcomes depend on computed values. A fault in the taken or not-taken decision therefore sends the PC onto a path where filler instructions overwrite a register. Wrap-around and re-execution after reset are observed directly at pc_o.

// File: rtl/nano8_pkg.sv
package nano8_pkg;
  localparam int DATA_W    = 8;
  localparam int PC_W      = 8;
  localparam int IW        = 16;
  localparam int NREG      = 4;
  localparam int RIDX_W    = $clog2(NREG);
  localparam int OP_W      = 4;
  localparam int ROM_DEPTH = 2 ** PC_W;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 4'd0,  OP_ADD  = 4'd1,  OP_SUB = 4'd2,  OP_NEG = 4'd3,
    OP_MUL  = 4'd4,  OP_MOV  = 4'd5,  OP_SHL = 4'd6,  OP_SHR = 4'd7,
    OP_AND  = 4'd8,  OP_OR   = 4'd9,  OP_XOR = 4'd10, OP_INV = 4'd11,
    OP_JZ   = 4'd12, OP_JMP  = 4'd13
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              use_imm;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs;
    logic [DATA_W-1:0] lit;
    logic              wr_en;
    logic              is_jmp;
    logic              is_jz;
  } dec_t;

  typedef logic [IW-1:0] rom_t [ROM_DEPTH];
endpackage

// File: rtl/nano8_rst_sync.sv
module nano8_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/nano8_fetch.sv
module nano8_fetch
  import nano8_pkg::*;
#(
  parameter rom_t PROGRAM = '{default: '0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [PC_W-1:0]   target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [IW-1:0]     instr_o
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    if (take_i) pc_d = target_i;
    else        pc_d = pc_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign instr_o = PROGRAM[pc_q];
  assign pc_o    = pc_q;
endmodule

// File: rtl/nano8_decode.sv
module nano8_decode
  import nano8_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  logic unused_pad;
  assign unused_pad = instr_i[8];

  always_comb begin
    dec_o.op      = op_e'(instr_i[15:12]);
    dec_o.use_imm = instr_i[11];
    dec_o.rd      = instr_i[10:9];
    dec_o.rs      = instr_i[RIDX_W-1:0];
    dec_o.lit     = instr_i[DATA_W-1:0];
    dec_o.wr_en   = 1'b0;
    dec_o.is_jmp  = 1'b0;
    dec_o.is_jz   = 1'b0;
    case (instr_i[15:12])
      OP_ADD, OP_SUB, OP_NEG, OP_MUL, OP_MOV, OP_SHL,
      OP_SHR, OP_AND, OP_OR,  OP_XOR, OP_INV: dec_o.wr_en  = 1'b1;
      OP_JZ:                                  dec_o.is_jz  = 1'b1;
      OP_JMP:                                 dec_o.is_jmp = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nano8_regfile.sv
module nano8_regfile
  import nano8_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RIDX_W-1:0]      wa_i,
  input  logic [DATA_W-1:0]      wd_i,
  input  logic [RIDX_W-1:0]      ra_a_i,
  input  logic [RIDX_W-1:0]      ra_b_i,
  output logic [DATA_W-1:0]      rd_a_o,
  output logic [DATA_W-1:0]      rd_b_o,
  output logic [NREG*DATA_W-1:0] dbg_o
);
  logic [DATA_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign en = we_i && (wa_i == RIDX_W'(g));

    always_comb begin
      if (en) d = wd_i;
      else    d = q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign bank[g]                   = q;
    assign dbg_o[g*DATA_W +: DATA_W] = q;
  end

  assign rd_a_o = bank[ra_a_i];
  assign rd_b_o = bank[ra_b_i];
endmodule

// File: rtl/nano8_alu.sv
module nano8_alu
  import nano8_pkg::*;
(
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_NEG:  y_o = DATA_W'(0) - a_i;
      OP_MUL:  y_o = a_i * b_i;
      OP_MOV:  y_o = b_i;
      OP_SHL:  y_o = {a_i[DATA_W-2:0], 1'b0};
      OP_SHR:  y_o = {1'b0, a_i[DATA_W-1:1]};
      OP_AND:  y_o = a_i & b_i;
      OP_OR:   y_o = a_i | b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_INV:  y_o = ~a_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/nano8_core.sv
module nano8_core
  import nano8_pkg::*;
#(
  parameter rom_t PROGRAM = '{default: '0}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [PC_W-1:0]        pc_o,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic              core_rst_n;
  logic [IW-1:0]     instr;
  dec_t              dec;
  logic [DATA_W-1:0] dst_val;
  logic [DATA_W-1:0] src_reg;
  logic [DATA_W-1:0] src_op;
  logic [DATA_W-1:0] alu_y;
  logic              take;

  nano8_rst_sync u_rst (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (core_rst_n)
  );

  nano8_fetch #(.PROGRAM(PROGRAM)) u_fetch (
    .clk_i    (clk),
    .rst_ni   (core_rst_n),
    .take_i   (take),
    .target_i (dec.lit),
    .pc_o     (pc_o),
    .instr_o  (instr)
  );

  nano8_decode u_dec (
    .instr_i (instr),
    .dec_o   (dec)
  );

  nano8_regfile u_rf (
    .clk_i  (clk),
    .rst_ni (core_rst_n),
    .we_i   (dec.wr_en),
    .wa_i   (dec.rd),
    .wd_i   (alu_y),
    .ra_a_i (dec.rd),
    .ra_b_i (dec.rs),
    .rd_a_o (dst_val),
    .rd_b_o (src_reg),
    .dbg_o  (regs_o)
  );

  assign src_op = dec.use_imm ? dec.lit : src_reg;

  nano8_alu u_alu (
    .op_i (dec.op),
    .a_i  (dst_val),
    .b_i  (src_op),
    .y_o  (alu_y)
  );

  assign take = dec.is_jmp | (dec.is_jz & (dst_val == '0));
endmodule

// File: rtl/nano8_chk.sv
module nano8_chk
  import nano8_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [PC_W-1:0]        pc_i,
  input logic [IW-1:0]          instr_i,
  input logic [NREG*DATA_W-1:0] regs_i
);
  logic [OP_W-1:0]   op;
  logic [RIDX_W-1:0] rd;
  logic [DATA_W-1:0] rd_val;
  logic              branchy;

  assign op      = instr_i[15:12];
  assign rd      = instr_i[10:9];
  assign rd_val  = regs_i[rd*DATA_W +: DATA_W];
  assign branchy = (op == OP_JZ) || (op == OP_JMP);

  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (regs_i == '0 && pc_i == '0)
        else $error("registers or pc not cleared in reset");
    end
  end

  // R2
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branchy |=> pc_i == $past(pc_i) + PC_W'(1));

  // R9
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JMP) |=> pc_i == $past(instr_i[7:0]));

  // R8
  jz_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JZ && rd_val == '0) |=> pc_i == $past(instr_i[7:0]));

  // R8
  jz_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_JZ && rd_val != '0) |=> pc_i == $past(pc_i) + PC_W'(1));

  // R10
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_IDLE || op >= OP_JZ) |=> $stable(regs_i));

  // R5
  mov_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_MOV && instr_i[11]) |=> regs_i[$past(rd)*DATA_W +: DATA_W] == $past(instr_i[7:0]));
endmodule

bind nano8_core nano8_chk u_chk (
  .clk_i   (clk),
  .rst_ni  (core_rst_n),
  .pc_i    (pc_o),
  .instr_i (instr),
  .regs_i  (regs_o)
);

// File: tb/nano8_core_bench.sv
module nano8_core_bench;
  import nano8_pkg::*;

  function automatic logic [15:0] enc(logic [3:0] op, logic im, logic [1:0] rd, logic [7:0] lo);
    return {op, im, rd, 1'b0, lo};
  endfunction

  function automatic rom_t build_prog();
    rom_t p;
    for (int i = 0; i < ROM_DEPTH; i++) p[i] = 16'h0000;
    p[0]  = enc(4'd5,  1, 2'd0, 8'h05);
    p[1]  = enc(4'd5,  1, 2'd1, 8'h03);
    p[2]  = enc(4'd1,  0, 2'd0, 8'hFD);
    p[3]  = enc(4'd1,  1, 2'd0, 8'd250);
    p[4]  = enc(4'd2,  1, 2'd1, 8'h05);
    p[5]  = enc(4'd2,  0, 2'd1, 8'h00);
    p[6]  = enc(4'd4,  1, 2'd1, 8'h03);
    p[7]  = enc(4'd5,  0, 2'd2, 8'h05);
    p[8]  = enc(4'd4,  0, 2'd2, 8'h00);
    p[9]  = enc(4'd3,  1, 2'd0, 8'h77);
    p[10] = enc(4'd6,  0, 2'd0, 8'h00);
    p[11] = enc(4'd7,  0, 2'd0, 8'h00);
    p[12] = enc(4'd8,  1, 2'd0, 8'h0F);
    p[13] = enc(4'd9,  1, 2'd0, 8'hA0);
    p[14] = enc(4'd10, 0, 2'd0, 8'hFA);
    p[15] = enc(4'd11, 1, 2'd0, 8'h33);
    p[16] = enc(4'd5,  1, 2'd3, 8'h5A);
    p[17] = enc(4'd8,  0, 2'd3, 8'h00);
    p[18] = enc(4'd9,  0, 2'd3, 8'h01);
    p[19] = enc(4'd10, 1, 2'd3, 8'hFF);
    p[20] = enc(4'd15, 1, 2'd3, 8'h77);
    p[21] = enc(4'd12, 1, 2'd3, 8'd40);
    p[22] = enc(4'd5,  1, 2'd3, 8'h00);
    p[23] = enc(4'd12, 1, 2'd3, 8'd30);
    for (int i = 24; i < 30; i++) p[i] = enc(4'd5, 1, 2'd0, 8'h11);
    p[30] = enc(4'd13, 1, 2'd0, 8'd250);
    p[40] = enc(4'd5,  1, 2'd2, 8'h11);
    p[250] = enc(4'd0, 1, 2'd1, 8'h99);
    p[251] = enc(4'd14, 1, 2'd2, 8'h42);
    return p;
  endfunction

  localparam rom_t PROG = build_prog();

  logic        clk;
  logic        rst_n;
  logic [7:0]  pc_o;
  logic [31:0] regs_o;

  int n_vec;
  int n_bad;
  logic [7:0] exp_r [4];
  logic [7:0] exp_pc;

  nano8_core #(.PROGRAM(PROG)) u_nano8_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_o   (pc_o),
    .regs_o (regs_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag);
    logic [31:0] exp_flat;
    exp_flat = {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
    n_vec++;
    if (regs_o !== exp_flat || pc_o !== exp_pc) begin
      n_bad++;
      $display("FAIL %s: regs=%h pc=%0d expected regs=%h pc=%0d",
               tag, regs_o, pc_o, exp_flat, exp_pc);
    end
  endtask

  task automatic retire();
    @(posedge clk);
    @(negedge clk);
    exp_pc = exp_pc + 8'd1;
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 4; i++) exp_r[i] = 8'h00;
    exp_pc = 8'd0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clear_exp();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 two edges after release, nothing retired");
  endtask

  task automatic t_arith();
    retire(); exp_r[0] = 8'h05; check("R5 move imm");
    retire(); exp_r[1] = 8'h03; check("R5 move imm second reg");
    retire(); exp_r[0] = exp_r[0] + exp_r[1]; check("R4 R12 add reg, bits 7:2 ignored");
    retire(); exp_r[0] = exp_r[0] + 8'd250; check("R4 add imm wraps");
    retire(); exp_r[1] = exp_r[1] - 8'd5; check("R4 sub imm borrow");
    retire(); exp_r[1] = exp_r[1] - exp_r[0]; check("R4 sub reg");
    retire(); exp_r[1] = exp_r[1] * 8'd3; check("R4 mul imm low byte");
    retire(); exp_r[2] = exp_r[1]; check("R5 R11 move reg");
    retire(); exp_r[2] = exp_r[2] * exp_r[0]; check("R4 mul reg");
  endtask

  task automatic t_unary_logic();
    retire(); exp_r[0] = 8'd0 - exp_r[0]; check("R7 negate ignores imm fields");
    retire(); exp_r[0] = {exp_r[0][6:0], 1'b0}; check("R7 shift left");
    retire(); exp_r[0] = {1'b0, exp_r[0][7:1]}; check("R7 shift right zero fill");
    retire(); exp_r[0] = exp_r[0] & 8'h0F; check("R6 and imm");
    retire(); exp_r[0] = exp_r[0] | 8'hA0; check("R6 or imm");
    retire(); exp_r[0] = exp_r[0] ^ exp_r[2]; check("R6 xor reg");
    retire(); exp_r[0] = ~exp_r[0]; check("R7 invert");
  endtask

  task automatic t_reg_logic();
    retire(); exp_r[3] = 8'h5A; check("R11 move into r3");
    retire(); exp_r[3] = exp_r[3] & exp_r[0]; check("R6 and reg");
    retire(); exp_r[3] = exp_r[3] | exp_r[1]; check("R6 or reg");
    retire(); exp_r[3] = exp_r[3] ^ 8'hFF; check("R6 xor imm");
    retire(); check("R10 opcode 15 writes nothing");
  endtask

  task automatic t_branch();
    retire(); check("R8 jump-if-zero not taken on nonzero");
    retire(); exp_r[3] = 8'h00; check("R5 clear r3");
    retire(); exp_pc = 8'd30; check("R8 jump-if-zero taken");
  endtask

  task automatic t_jump_wrap();
    retire(); exp_pc = 8'd250; check("R9 R10 jump, no register write");
    retire(); check("R10 idle with fields set");
    retire(); check("R10 opcode 14 writes nothing");
    for (int i = 252; i < 255; i++) retire();
    check("R2 sequential up to 255");
    retire(); exp_pc = 8'd0; check("R2 pc wraps to 0");
    retire(); exp_r[0] = 8'h05; check("R2 re-execution after wrap");
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    clear_exp();
    check("R1 asynchronous clear mid-cycle");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 held through synchroniser");
    retire(); exp_r[0] = 8'h05; check("R1 first retire on third edge");
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    t_reset();
    t_arith();
    t_unary_logic();
    t_reg_logic();
    t_branch();
    t_jump_wrap();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule